// File: doc/BRIEF.md
# Byte-Addressed Word Bus Sequencer

This block sits between a core and an external memory/I/O bus. The core sees a byte-addressed 1 MB space and asks for one 8-bit or 16-bit read or write at a time. The block turns each request into one or two bus cycles. It drives a 20-bit address, separate active-low read and write strobes, a memory/I/O select and the outgoing data. It waits on a ready input, collects the returned bytes into a little-endian result, and tells the core when it is finished.

The external data path is set by a parameter. The wide build is 16 bits, split into an even-address byte bank and an odd-address byte bank. The narrow build is 8 bits. The wide build also drives an active-low enable for the odd bank; the even bank is chosen by address bit 0 being low. The number of bus cycles depends on the data width, the transfer size and the parity of the address.

Top module: `bus_word_seq`

## Requirements
- R1: While reset is applied and right after it is released, both strobes are high, and `busy` and `done` are low.
- R2: `bus_io` is 1 for an I/O request and 0 for a memory request. It holds that value through every bus cycle of the request.
- R3: On the 16-bit bus, a word at an even address A takes one bus cycle at address A with `bus_hi_n`=0. The read result is the full data input: the lower lane is the byte at A and the upper lane is the byte at A+1.
- R4: On the 16-bit bus, a word at an odd address A takes two bus cycles. The first is at A with `bus_hi_n`=0, and the result's low byte comes from the upper lane. The second is at A+1 with `bus_hi_n`=1, and the result's high byte comes from the lower lane.
- R5: On the 16-bit bus, a byte transfer takes one cycle at A. `bus_hi_n` is 1 for even A, with data on the lower lane. It is 0 for odd A, with data on the upper lane. Byte reads return the byte in bits 7:0 with bits 15:8 zero. During any wide-bus strobe, at least one bank is enabled.
- R6: On the 8-bit bus, a word takes two byte cycles: low byte at A, then high byte at A+1. A byte takes one cycle. `bus_hi_n` stays 1.
- R7: A strobe stays low until `bus_ready` is sampled high. Between the two cycles of a split transfer, both strobes are high for exactly one clock.
- R8: `done` is a one-clock pulse in the clock after the last cycle's ready sample. `rdata` is valid with it and holds until the next transfer captures data.
- R9: Write data for an even word on the 16-bit bus is the whole word, with the low byte on the lower lane. In every other 16-bit-bus write cycle, the byte of that cycle (low byte first) is copied onto both lanes. On the 8-bit bus, the byte of the cycle is driven.
- R10: The address A+1 of a split cycle wraps within 20 bits, so FFFFFh is followed by 00000h.
- R11: A request raised while `busy` is high is ignored. No extra bus cycle results and the running transfer is unchanged.
- R12: Only `bus_wr_n` is driven low for writes, and only `bus_rd_n` for reads. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, accepted when not busy |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data, low byte first |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read result |
| bus_addr | output | AW | External address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io | output | 1 | Memory (0) / I/O (1) select |
| bus_hi_n | output | 1 | Odd-bank enable, active low |
| bus_dout | output | DW | Outgoing data |
| bus_din | input | DW | Incoming data |
| bus_ready | input | 1 | Ends the current bus cycle when high |

## Verification
The bench builds two copies side by side, one with DW=16 and one with DW=8, both with the default 20-bit address. The wide copy covers the bank enables, lane steering, odd-word splitting and wrap at the top of the space. The narrow copy covers two byte cycles for every word. Wait counts from zero to four check strobe holding and the single idle clock between split cycles. A request raised during a long transfer checks that busy requests are ignored.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2
  } bws_state_e;

  // A request needs a second bus cycle when it is a word and either the
  // bus is narrow or the word starts on an odd byte.
  function automatic logic needs_split(input logic wide, input logic word,
                                       input logic a0);
    return word & (~wide | a0);
  endfunction

  // Single-cycle whole-word transfer on the wide bus.
  function automatic logic whole_word(input logic wide, input logic word,
                                      input logic a0);
    return wide & word & ~a0;
  endfunction

  // Active-low odd-bank enable for the current step.
  function automatic logic odd_bank_off(input logic wide, input logic word,
                                        input logic step_a0, input logic step);
    if (!wide) return 1'b1;
    if (step)  return 1'b1;
    if (word)  return 1'b0;
    return ~step_a0;
  endfunction

  // Byte taken from the data bus for the current step.
  function automatic logic [BYTE_W-1:0] lane_byte(input logic [WORD_W-1:0] bus,
                                                  input logic wide,
                                                  input logic odd);
    return (wide && odd) ? bus[WORD_W-1:BYTE_W] : bus[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/bws_ctrl.sv
module bws_ctrl #(
  parameter int AW   = 20,
  parameter bit WIDE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic                       req_word,
  input  logic                       req_wr,
  input  logic                       req_io,
  input  logic [AW-1:0]              req_addr,
  input  logic [bws_pkg::WORD_W-1:0] req_wdata,
  input  logic                       bus_ready,
  output logic                       busy,
  output logic                       done,
  output logic                       cur_word,
  output logic                       cur_wr,
  output logic                       cur_io,
  output logic [AW-1:0]              cur_addr,
  output logic [bws_pkg::WORD_W-1:0] cur_wdata,
  output logic                       step,
  output logic                       strobe_on,
  output logic                       capture
);
  import bws_pkg::*;

  bws_state_e state_q;
  logic       last_step;
  logic       accept;

  assign busy      = (state_q != ST_IDLE);
  assign strobe_on = (state_q == ST_STROBE);
  assign capture   = strobe_on & bus_ready;
  assign accept    = req & (state_q == ST_IDLE);
  assign last_step = ~needs_split(WIDE, cur_word, cur_addr[0]) | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step      <= 1'b0;
      done      <= 1'b0;
      cur_word  <= 1'b0;
      cur_wr    <= 1'b0;
      cur_io    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cur_word  <= req_word;
            cur_wr    <= req_wr;
            cur_io    <= req_io;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            step      <= 1'b0;
            state_q   <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (bus_ready) begin
            if (last_step) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              state_q <= ST_GAP;
              step    <= 1'b1;
            end
          end
        end
        ST_GAP:  state_q <= ST_STROBE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n) (strobe_on && !bus_ready) |=> strobe_on);  // R7
  AST_SPLIT_GAP: assert property (@(posedge clk) disable iff (!rst_n) (capture && !last_step) |=> (!strobe_on && busy));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);  // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(capture && last_step));  // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(cur_addr) && $stable(cur_wr)));  // R11
endmodule

// File: rtl/bws_addr.sv
module bws_addr #(
  parameter int AW   = 20,
  parameter bit WIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_addr,
  input  logic          cur_word,
  input  logic          step,
  input  logic          strobe_on,
  output logic [AW-1:0] bus_addr,
  output logic          bus_hi_n,
  output logic          step_a0
);
  import bws_pkg::*;

  // Second step moves to the next byte; the sum wraps within AW bits.
  assign bus_addr = cur_addr + {{(AW-1){1'b0}}, step};
  assign step_a0  = bus_addr[0];
  assign bus_hi_n = odd_bank_off(WIDE, cur_word, step_a0, step);

  if (WIDE) begin : g_wide_chk
    AST_BANK_ON: assert property (@(posedge clk) disable iff (!rst_n) strobe_on |-> !(bus_hi_n && bus_addr[0]));  // R5
  end else begin : g_narrow_chk
    AST_NARROW_HI: assert property (@(posedge clk) disable iff (!rst_n) strobe_on |-> bus_hi_n);  // R6
  end
endmodule

// File: rtl/bws_lanes.sv
module bws_lanes #(
  parameter int DW   = 16,
  parameter bit WIDE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cur_word,
  input  logic [bws_pkg::WORD_W-1:0] cur_wdata,
  input  logic                       start_a0,
  input  logic                       step_a0,
  input  logic                       step,
  input  logic                       capture,
  input  logic [DW-1:0]              bus_din,
  output logic [DW-1:0]              bus_dout,
  output logic [bws_pkg::WORD_W-1:0] rdata
);
  import bws_pkg::*;

  localparam int LANES = DW / BYTE_W;

  logic              full;
  logic [BYTE_W-1:0] wbyte;
  logic [BYTE_W-1:0] rbyte;
  logic [WORD_W-1:0] din_w;

  assign full  = whole_word(WIDE, cur_word, start_a0);
  assign wbyte = step ? cur_wdata[WORD_W-1:BYTE_W] : cur_wdata[BYTE_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bus_dout[l*BYTE_W +: BYTE_W] = full ? cur_wdata[l*BYTE_W +: BYTE_W] : wbyte;
  end

  if (LANES == 2) begin : g_din_wide
    assign din_w = bus_din;
  end else begin : g_din_narrow
    assign din_w = {{(WORD_W-DW){1'b0}}, bus_din};
  end

  assign rbyte = lane_byte(din_w, WIDE, step_a0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      if (full)      rdata <= din_w;
      else if (step) rdata[WORD_W-1:BYTE_W] <= rbyte;
      else           rdata <= {{(WORD_W-BYTE_W){1'b0}}, rbyte};
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(capture) |-> $stable(rdata));  // R8
endmodule

// File: rtl/bus_word_seq.sv
module bus_word_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_word,
  input  logic          req_wr,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_io,
  output logic          bus_hi_n,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready
);
  import bws_pkg::*;

  localparam bit WIDE = (DW == 2 * BYTE_W);

  logic              cur_word, cur_wr, cur_io;
  logic [AW-1:0]     cur_addr;
  logic [WORD_W-1:0] cur_wdata;
  logic              step, strobe_on, capture, step_a0;

  bws_ctrl #(.AW(AW), .WIDE(WIDE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_word(req_word), .req_wr(req_wr),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_ready(bus_ready), .busy(busy), .done(done), .cur_word(cur_word),
    .cur_wr(cur_wr), .cur_io(cur_io), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .step(step), .strobe_on(strobe_on), .capture(capture)
  );

  bws_addr #(.AW(AW), .WIDE(WIDE)) u_addr (
    .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .cur_word(cur_word),
    .step(step), .strobe_on(strobe_on), .bus_addr(bus_addr),
    .bus_hi_n(bus_hi_n), .step_a0(step_a0)
  );

  bws_lanes #(.DW(DW), .WIDE(WIDE)) u_lanes (
    .clk(clk), .rst_n(rst_n), .cur_word(cur_word), .cur_wdata(cur_wdata),
    .start_a0(cur_addr[0]), .step_a0(step_a0), .step(step), .capture(capture),
    .bus_din(bus_din), .bus_dout(bus_dout), .rdata(rdata)
  );

  assign bus_rd_n = ~(strobe_on & ~cur_wr);
  assign bus_wr_n = ~(strobe_on & cur_wr);
  assign bus_io   = cur_io;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_rd_n && !bus_wr_n));  // R12
  AST_IO_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(bus_io));  // R2
endmodule

// File: tb/bus_word_seq_harness.sv
module bus_word_seq_harness #(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_run,
  output int   n_fail,
  output logic finished
);
  localparam bit WIDE = (DW == 16);

  typedef struct packed {
    logic [19:0] a;
    logic        hi_n;
    logic        io;
    logic        wr;
    logic [15:0] d;
  } exp_t;

  logic          req = 1'b0, req_word = 1'b0, req_wr = 1'b0, req_io = 1'b0;
  logic [19:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          busy, done;
  logic [15:0]   rdata;
  logic [19:0]   bus_addr;
  logic          bus_rd_n, bus_wr_n, bus_io, bus_hi_n;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic          bus_ready = 1'b0;

  int    runs = 0, fails = 0, waits = 0, lowcnt = 0;
  bit    prev_low = 1'b0;
  exp_t  expq[$];
  string tagq[$];
  exp_t  e;
  string tg;

  assign n_run  = runs;
  assign n_fail = fails;

  bus_word_seq #(.AW(20), .DW(DW)) u_bus_word_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_word(req_word), .req_wr(req_wr),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_io(bus_io), .bus_hi_n(bus_hi_n),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ready(bus_ready)
  );

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL DW=%0d %s: actual=%h expected=%h", DW, tag, act, expv);
    end
  endtask

  task automatic push(input logic [19:0] a, input logic hi, input logic io,
                      input logic wr, input logic [15:0] d, input string t);
    exp_t x;
    x.a = a; x.hi_n = hi; x.io = io; x.wr = wr; x.d = d;
    expq.push_back(x);
    tagq.push_back(t);
  endtask

  // Bus responder and cycle monitor, evaluated between active edges.
  always @(negedge clk) begin
    if (!rst_n) begin
      lowcnt    = 0;
      prev_low  = 1'b0;
      bus_ready = 1'b0;
    end else begin
      if (!bus_rd_n || !bus_wr_n) begin
        if (!prev_low) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R11 unexpected bus cycle", 32'(bus_addr), 32'h0);
          end else begin
            e  = expq.pop_front();
            tg = tagq.pop_front();
            chk(bus_addr == e.a, {tg, " address"}, 32'(bus_addr), 32'(e.a));
            chk(bus_hi_n == e.hi_n, {tg, " odd bank enable"}, 32'(bus_hi_n), 32'(e.hi_n));
            chk(bus_io == e.io, "R2 io select", 32'(bus_io), 32'(e.io));
            chk(bus_wr_n == !e.wr && bus_rd_n == e.wr, "R12 strobe choice",
                {30'd0, bus_rd_n, bus_wr_n}, {30'd0, e.wr, !e.wr});
            if (e.wr)
              chk(16'(bus_dout) == e.d, "R9 write lanes", 32'(bus_dout), 32'(e.d));
          end
        end
        lowcnt++;
        bus_ready = (lowcnt >= waits + 1);
        if (WIDE) bus_din = DW'({mb({bus_addr[19:1], 1'b1}), mb({bus_addr[19:1], 1'b0})});
        else      bus_din = DW'(mb(bus_addr));
        prev_low = 1'b1;
      end else begin
        if (prev_low)
          chk(lowcnt == waits + 1, "R7 strobe length", lowcnt, waits + 1);
        lowcnt    = 0;
        bus_ready = 1'b0;
        prev_low  = 1'b0;
      end
    end
  end

  task automatic xfer(input bit word, input bit wr, input bit io,
                      input logic [19:0] a, input logic [15:0] wd, input int w,
                      input string tag, input bit poke);
    logic [19:0] a1;
    logic [15:0] exp_r;
    int          cyc;
    string       t;
    a1 = a + 20'd1;
    t  = (WIDE || poke) ? tag : "R6";
    waits = w;
    if (WIDE) begin
      if (word && !a[0]) push(a, 1'b0, io, wr, wd, t);
      else if (word) begin
        push(a,  1'b0, io, wr, {wd[7:0], wd[7:0]}, t);
        push(a1, 1'b1, io, wr, {wd[15:8], wd[15:8]}, t);
      end else push(a, ~a[0], io, wr, {wd[7:0], wd[7:0]}, t);
    end else begin
      push(a, 1'b1, io, wr, {8'h00, wd[7:0]}, t);
      if (word) push(a1, 1'b1, io, wr, {8'h00, wd[15:8]}, t);
    end
    exp_r = word ? {mb(a1), mb(a)} : {8'h00, mb(a)};
    req_word = word; req_wr = wr; req_io = io; req_addr = a; req_wdata = wd;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      req_addr = a ^ 20'h00F0F; req_wr = ~wr; req_word = ~word; req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R8 done pulse", 32'(done), 32'd1);
    chk(expq.size() == 0, {t, " cycle count"}, expq.size(), 0);
    if (!wr) chk(rdata == exp_r, {t, " read result"}, 32'(rdata), 32'(exp_r));
    @(negedge clk);
    chk(!done, "R8 done one clock", 32'(done), 32'd0);
    if (!wr) chk(rdata == exp_r, "R8 rdata held", 32'(rdata), 32'(exp_r));
  endtask

  initial begin
    finished = 1'b0;
    @(negedge clk);
    chk(!rst_n && bus_rd_n && bus_wr_n && !busy && !done, "R1 during reset",
        {28'd0, bus_rd_n, bus_wr_n, busy, done}, 32'hC);
    wait (rst_n);
    @(negedge clk);
    chk(bus_rd_n && bus_wr_n && !busy && !done, "R1 after reset",
        {28'd0, bus_rd_n, bus_wr_n, busy, done}, 32'hC);
    xfer(1'b1, 1'b0, 1'b0, 20'h12344, 16'h0000, 0, "R3", 1'b0);
    xfer(1'b1, 1'b0, 1'b0, 20'h12345, 16'h0000, 1, "R4", 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 20'h00100, 16'h0000, 0, "R5", 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 20'h00101, 16'h0000, 2, "R5", 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 20'h20000, 16'hA55A, 0, "R9", 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 20'h20001, 16'hBEEF, 1, "R9", 1'b0);
    xfer(1'b0, 1'b1, 1'b0, 20'h20003, 16'h77C3, 0, "R9", 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 20'h003F8, 16'h0000, 0, "R2", 1'b0);
    xfer(1'b0, 1'b1, 1'b1, 20'h00061, 16'h1234, 1, "R2", 1'b0);
    xfer(1'b1, 1'b0, 1'b0, 20'hFFFFF, 16'h0000, 0, "R10", 1'b0);
    xfer(1'b1, 1'b0, 1'b0, 20'h0ABC0, 16'h0000, 4, "R11", 1'b0 | 1'b1);
    xfer(1'b1, 1'b0, 1'b0, 20'h0ABC7, 16'h0000, 3, "R7", 1'b0);
    xfer(1'b1, 1'b1, 1'b1, 20'h0ABC9, 16'h6B2D, 0, "R7", 1'b0);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0 && !busy, "R11 no trailing cycles", expq.size(), 0);
    finished = 1'b1;
  end
endmodule

// File: tb/bus_word_seq_bench.sv
module bus_word_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   r16, f16, r8, f8;
  logic d16, d8;

  always #10 clk = ~clk;

  bus_word_seq_harness #(.DW(16)) u_h16 (
    .clk(clk), .rst_n(rst_n), .n_run(r16), .n_fail(f16), .finished(d16)
  );
  bus_word_seq_harness #(.DW(8)) u_h8 (
    .clk(clk), .rst_n(rst_n), .n_run(r8), .n_fail(f8), .finished(d8)
  );

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc;
    int total;
    int failed;
    cyc = 0;
    while (!(d16 === 1'b1 && d8 === 1'b1) && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    total  = r16 + r8;
    failed = f16 + f8;
    if (!(d16 === 1'b1 && d8 === 1'b1)) begin
      total++;
      failed++;
      $display("FAIL R8 watchdog: actual=%0d cycles expected completion", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule